// File: doc/BRIEF.md
# Byte ALU with microcontroller flag semantics

This block is the arithmetic and logic stage of a small 8-bit controller core. It is purely combinational. The core applies an operation code, two source bytes and the current carry and auxiliary-carry flags. Within the same cycle the block returns one or two result bytes and the next values of the carry, auxiliary-carry and overflow flags. The core decodes instructions and holds the accumulator and the flag register, and it latches whatever this block computes.

Sixteen operations are selected by a 4-bit code. They cover binary addition and subtraction with borrow, increment and decrement, bitwise logic, four rotates, an unsigned 8x8 multiply, an unsigned 8/8 divide and a decimal correction step for packed BCD sums. Multiply and divide use the second result byte. Every other operation drives it to zero. A synchronous-free reset input forces every output low while it is held.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is 1, `res_lo`, `res_hi`, `cy_out`, `ac_out` and `ov_out` are all 0 for every opcode and operand value.
- R2: Opcode 0 (add) gives `res_lo` = (a+b) mod 256 and ignores `cy_in`. Opcode 1 (add with carry) gives (a+b+cy_in) mod 256. For both, `cy_out` is the carry out of bit 7, `ac_out` is the carry out of bit 3, and `ov_out` is 1 exactly when the signed sum lies outside -128..127.
- R3: Opcode 2 (subtract with borrow) gives `res_lo` = (a-b-cy_in) mod 256. `cy_out` is 1 when a < b+cy_in, `ac_out` is 1 when a[3:0] < b[3:0]+cy_in, and `ov_out` is 1 when the signed difference lies outside -128..127.
- R4: Opcode 3 gives (a+1) mod 256 and opcode 4 gives (a-1) mod 256. For both, `cy_out`, `ac_out` and `ov_out` equal `cy_in`, `ac_in` and 0 respectively.
- R5: Opcodes 5, 6 and 7 give a AND b, a OR b and a XOR b. Opcode 8 gives NOT a. For these, `cy_out` = `cy_in`, `ac_out` = `ac_in` and `ov_out` = 0.
- R6: Opcode 9 rotates a left by one (bit 7 into bit 0) and opcode 11 rotates it right by one (bit 0 into bit 7). For both, `cy_out` = `cy_in`, `ac_out` = `ac_in` and `ov_out` = 0.
- R7: Opcode 10 gives {a[6:0], cy_in} with `cy_out` = a[7]. Opcode 12 gives {cy_in, a[7:1]} with `cy_out` = a[0]. For both, `ac_out` = `ac_in` and `ov_out` = 0.
- R8: Opcode 13 puts the low byte of a*b on `res_lo` and the high byte on `res_hi`. It clears `cy_out`, sets `ov_out` exactly when the high byte is non-zero, and passes `ac_in` through.
- R9: Opcode 14 with b != 0 puts floor(a/b) on `res_lo` and a mod b on `res_hi`, with `cy_out` = 0 and `ov_out` = 0. With b = 0 both results are 0xFF, `ov_out` = 1 and `cy_out` = 0. In both cases `ac_out` = `ac_in`.
- R10: Opcode 15 first adds 0x06 to a when a[3:0] > 9 or `ac_in` = 1. It then adds 0x60 when the intermediate high nibble is > 9, when `cy_in` = 1, or when the first addition carried out of bit 7. `cy_out` is 1 when that second addition happens, so a set `cy_in` is never cleared. `ac_out` = `ac_in` and `ov_out` = 0.
- R11: When `rst` is 0 and the opcode is neither 13 nor 14, `res_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Forces all outputs to zero while high |
| op | input | 4 | Operation code |
| src_a | input | 8 | First source byte (a) |
| src_b | input | 8 | Second source byte (b) |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| res_lo | output | 8 | Primary result byte |
| res_hi | output | 8 | Secondary result byte (product high byte or remainder) |
| cy_out | output | 1 | Next carry flag |
| ac_out | output | 1 | Next auxiliary-carry flag |
| ov_out | output | 1 | Next overflow flag |

## Verification
The embedded checks assume that the inputs are stable and free of X once the combinational logic has settled. They also assume that the opcode is one of the sixteen defined codes, which a 4-bit field always is. The bench changes inputs only at whole time steps and waits one step before it compares, so each check sees settled values. It sweeps every opcode, every value of a, both flag inputs and eighteen evenly spaced values of b that include 0 and 255, so the zero-divisor path, both nibble-carry edges and signed-overflow boundaries all occur.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'h0, OP_ADDC = 4'h1, OP_SUBB = 4'h2, OP_INC  = 4'h3,
    OP_DEC  = 4'h4, OP_AND  = 4'h5, OP_OR   = 4'h6, OP_XOR  = 4'h7,
    OP_CPL  = 4'h8, OP_RL   = 4'h9, OP_RLC  = 4'hA, OP_RR   = 4'hB,
    OP_RRC  = 4'hC, OP_MUL  = 4'hD, OP_DIV  = 4'hE, OP_DA   = 4'hF
  } alu_op_e;

  // nibble above the largest decimal digit
  function automatic logic nib_over9(input logic [NW-1:0] n);
    return n > NW'(9);
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cy,
  output logic          ac,
  output logic          ov
);
  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [NW:0]   low_s;
  logic [NW-1:0] mid_s;
  logic          c_mid;
  logic [1:0]    top_s;
  // named carries for the checks
  logic c_nib, c_msb_in, c_msb_out;

  always_comb begin
    b_eff     = sub ? ~b : b;
    c_eff     = sub ? ~cin : cin;
    low_s     = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
    c_nib     = low_s[NW];
    {c_mid, mid_s[NW-2:0]} = {1'b0, a[DW-2:NW]} + {1'b0, b_eff[DW-2:NW]} + {{(NW-1){1'b0}}, c_nib};
    mid_s[NW-1] = 1'b0;
    c_msb_in  = c_mid;
    top_s     = {1'b0, a[DW-1]} + {1'b0, b_eff[DW-1]} + {1'b0, c_msb_in};
    c_msb_out = top_s[1];
    sum       = {top_s[0], mid_s[NW-2:0], low_s[NW-1:0]};
    cy        = sub ? ~c_msb_out : c_msb_out;
    ac        = sub ? ~c_nib : c_nib;
    ov        = c_msb_in ^ c_msb_out;
  end

  // R2 R3: signed overflow only when operand signs allow it
  always_comb begin
    if (ov) begin
      // R2
      add_ov_sign_chk: assert (sub || (a[DW-1] == b[DW-1]));
      // R3
      sub_ov_sign_chk: assert (!sub || (a[DW-1] != b[DW-1]));
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cy
);
  always_comb begin
    res = '0;
    cy  = cin;
    unique case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_CPL: res = ~a;
      OP_RL:  res = {a[DW-2:0], a[DW-1]};
      OP_RR:  res = {a[0], a[DW-1:1]};
      OP_RLC: begin res = {a[DW-2:0], cin}; cy = a[DW-1]; end
      OP_RRC: begin res = {cin, a[DW-1:1]}; cy = a[0]; end
      default: res = '0;
    endcase
  end

  always_comb begin
    if (op == OP_RL || op == OP_RR) begin
      // R6
      rot_ones_chk: assert ($countones(res) == $countones(a));
    end
    if (op == OP_RLC || op == OP_RRC) begin
      // R7
      rotc_ones_chk: assert (($countones(res) + int'(cy)) == ($countones(a) + int'(cin)));
    end
  end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] prod_lo,
  output logic [DW-1:0] prod_hi,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          div_zero
);
  logic [2*DW-1:0] prod;

  always_comb begin
    prod     = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    prod_lo  = prod[DW-1:0];
    prod_hi  = prod[2*DW-1:DW];
    div_zero = (b == '0);
    quo      = div_zero ? '1 : a / b;
    rem      = div_zero ? '1 : a % b;
  end

  always_comb begin
    // R8
    mul_hi_bound_chk: assert (a == '0 || prod_hi < a);
    if (!div_zero) begin
      // R9
      div_recon_chk: assert (({{DW{1'b0}}, quo} * {{DW{1'b0}}, b} + {{DW{1'b0}}, rem}) == {{DW{1'b0}}, a});
      // R9
      div_rem_chk: assert (rem < b);
    end
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic          acin,
  output logic [DW-1:0] res,
  output logic          cy
);
  logic          fix_lo, fix_hi, c_step1;
  logic [DW:0]   step1;
  logic [DW-1:0] step2;

  always_comb begin
    fix_lo  = nib_over9(a[NW-1:0]) || acin;
    step1   = {1'b0, a} + (fix_lo ? (DW+1)'(8'h06) : '0);
    c_step1 = step1[DW];
    fix_hi  = nib_over9(step1[DW-1:NW]) || cin || c_step1;
    step2   = step1[DW-1:0] + (fix_hi ? DW'(8'h60) : '0);
    res     = step2;
    cy      = fix_hi;
  end

  always_comb begin
    // R10
    da_keep_cy_chk: assert (!cin || cy);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic           rst,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  src_a,
  input  logic [DW-1:0]  src_b,
  input  logic           cy_in,
  input  logic           ac_in,
  output logic [DW-1:0]  res_lo,
  output logic [DW-1:0]  res_hi,
  output logic           cy_out,
  output logic           ac_out,
  output logic           ov_out
);
  alu_op_e opc;
  assign opc = alu_op_e'(op);

  // adder operand selection
  logic [DW-1:0] as_b;
  logic          as_cin, as_sub;
  always_comb begin
    as_b   = src_b;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (opc)
      OP_ADDC: as_cin = cy_in;
      OP_SUBB: begin as_cin = cy_in; as_sub = 1'b1; end
      OP_INC:  as_b = DW'(1);
      OP_DEC:  begin as_b = DW'(1); as_sub = 1'b1; end
      default: ;
    endcase
  end

  logic [DW-1:0] as_sum, bo_res, md_lo, md_hi, md_q, md_r, da_res;
  logic          as_cy, as_ac, as_ov, bo_cy, md_dz, da_cy;

  alu8_addsub u_addsub (
    .a(src_a), .b(as_b), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .cy(as_cy), .ac(as_ac), .ov(as_ov)
  );

  alu8_bitops u_bitops (
    .op(opc), .a(src_a), .b(src_b), .cin(cy_in),
    .res(bo_res), .cy(bo_cy)
  );

  alu8_muldiv u_muldiv (
    .a(src_a), .b(src_b), .prod_lo(md_lo), .prod_hi(md_hi),
    .quo(md_q), .rem(md_r), .div_zero(md_dz)
  );

  alu8_decadj u_decadj (
    .a(src_a), .cin(cy_in), .acin(ac_in), .res(da_res), .cy(da_cy)
  );

  always_comb begin
    res_lo = '0;
    res_hi = '0;
    cy_out = cy_in;
    ac_out = ac_in;
    ov_out = 1'b0;
    if (!rst) begin
      unique case (opc)
        OP_ADD, OP_ADDC, OP_SUBB: begin
          res_lo = as_sum; cy_out = as_cy; ac_out = as_ac; ov_out = as_ov;
        end
        OP_INC, OP_DEC: res_lo = as_sum;
        OP_AND, OP_OR, OP_XOR, OP_CPL,
        OP_RL, OP_RLC, OP_RR, OP_RRC: begin
          res_lo = bo_res; cy_out = bo_cy;
        end
        OP_MUL: begin
          res_lo = md_lo; res_hi = md_hi; cy_out = 1'b0; ov_out = (md_hi != '0);
        end
        OP_DIV: begin
          res_lo = md_q; res_hi = md_r; cy_out = 1'b0; ov_out = md_dz;
        end
        OP_DA: begin
          res_lo = da_res; cy_out = da_cy;
        end
        default: ;
      endcase
    end else begin
      cy_out = 1'b0;
      ac_out = 1'b0;
    end
  end

  always_comb begin
    if (rst) begin
      // R1
      rst_zero_chk: assert (res_lo == '0 && res_hi == '0 && !cy_out && !ac_out && !ov_out);
    end else if (opc != OP_MUL && opc != OP_DIV) begin
      // R11
      hi_idle_chk: assert (res_hi == '0);
    end
  end
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op;
  logic [7:0] src_a, src_b;
  logic       cy_in, ac_in;
  logic [7:0] res_lo, res_hi;
  logic       cy_out, ac_out, ov_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  alu8_core dut_i (
    .rst(rst), .op(op), .src_a(src_a), .src_b(src_b),
    .cy_in(cy_in), .ac_in(ac_in),
    .res_lo(res_lo), .res_hi(res_hi),
    .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
  );

  function automatic string tag_of(input int o);
    case (o)
      0, 1:  return "R2";
      2:     return "R3";
      3, 4:  return "R4";
      5, 6, 7, 8: return "R5";
      9, 11: return "R6";
      10, 12: return "R7";
      13:    return "R8";
      14:    return "R9";
      default: return "R10";
    endcase
  endfunction

  // expected {lo, hi, cy, ac, ov} from integer arithmetic
  function automatic logic [18:0] model(input int o, input int a, input int b,
                                        input int c, input int h);
    int lo, hi, cy, ac, ov, s, sa, sb;
    lo = 0; hi = 0; cy = c; ac = h; ov = 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (o)
      0, 1: begin
        s  = (o == 1) ? c : 0;
        lo = (a + b + s) % 256;
        cy = (a + b + s > 255) ? 1 : 0;
        ac = ((a % 16) + (b % 16) + s > 15) ? 1 : 0;
        ov = (sa + sb + s > 127 || sa + sb + s < -128) ? 1 : 0;
      end
      2: begin
        lo = (a - b - c + 512) % 256;
        cy = (a < b + c) ? 1 : 0;
        ac = ((a % 16) < (b % 16) + c) ? 1 : 0;
        ov = (sa - sb - c > 127 || sa - sb - c < -128) ? 1 : 0;
      end
      3: lo = (a + 1) % 256;
      4: lo = (a + 255) % 256;
      5: lo = a & b;
      6: lo = a | b;
      7: lo = a ^ b;
      8: lo = 255 - a;
      9:  lo = (a * 2) % 256 + a / 128;
      11: lo = a / 2 + (a % 2) * 128;
      10: begin lo = (a * 2) % 256 + c; cy = a / 128; end
      12: begin lo = a / 2 + c * 128; cy = a % 2; end
      13: begin lo = (a * b) % 256; hi = (a * b) / 256; cy = 0; ov = (a * b > 255) ? 1 : 0; end
      14: begin
        cy = 0;
        if (b == 0) begin lo = 255; hi = 255; ov = 1; end
        else begin lo = a / b; hi = a % b; end
      end
      default: begin
        s = a;
        if ((s % 16) > 9 || h == 1) s = s + 6;
        if (s > 255) begin cy = 1; s = s - 256; end
        if ((s / 16) > 9 || cy == 1) begin s = s + 96; cy = 1; end
        lo = s % 256;
      end
    endcase
    return {lo[7:0], hi[7:0], cy[0], ac[0], ov[0]};
  endfunction

  task automatic apply(input int o, input int a, input int b, input int c, input int h);
    op = o[3:0]; src_a = a[7:0]; src_b = b[7:0]; cy_in = c[0]; ac_in = h[0];
    #1;
  endtask

  task automatic check_vec(input int o, input int a, input int b, input int c, input int h);
    logic [18:0] exp;
    exp = model(o, a, b, c, h);
    apply(o, a, b, c, h);
    n_chk++;
    if ({res_lo, cy_out, ac_out, ov_out} !== {exp[18:11], exp[2:0]}) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%0d b=%0d c=%0d ac=%0d: got lo=%0d cy=%0d ac=%0d ov=%0d exp lo=%0d cy=%0d ac=%0d ov=%0d",
               tag_of(o), o, a, b, c, h, res_lo, cy_out, ac_out, ov_out,
               exp[18:11], exp[2], exp[1], exp[0]);
    end
    n_chk++;
    if (res_hi !== exp[10:3]) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%0d b=%0d: got hi=%0d exp hi=%0d",
               (o == 13 || o == 14) ? tag_of(o) : "R11", o, a, b, res_hi, exp[10:3]);
    end
  endtask

  initial begin
    rst = 1'b1; op = '0; src_a = '0; src_b = '0; cy_in = 1'b0; ac_in = 1'b0;
    #2;
    // R1: reset forces zeros for all opcodes and busy operands
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 4; k++) begin
        apply(o, 255 - k * 37, k * 51, k % 2, k / 2);
        n_chk++;
        if ({res_lo, res_hi, cy_out, ac_out, ov_out} !== 19'd0) begin
          n_bad++;
          $display("FAIL R1 op=%0d: got lo=%0d hi=%0d cy=%0d ac=%0d ov=%0d exp all 0",
                   o, res_lo, res_hi, cy_out, ac_out, ov_out);
        end
      end
    end
    rst = 1'b0;
    // R2..R11: sweep opcodes, all a, spaced b, all flag inputs
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 18; k++)
          for (int f = 0; f < 4; f++)
            check_vec(o, a, k * 15, f % 2, f / 2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule